// File: doc/BRIEF.md
# Keyed Two-Stage Watchdog

This block guards a processor against a hung program. Software controls it through a single write-only register made of a run bit and a 3-bit key. A write with the run bit set arms an idle watchdog and records the written key. From then on, software must keep servicing it. A service write carries the bitwise complement of the stored key, so the key alternates from one service write to the next. A stray write that repeats an old key, or any other value, cannot keep a runaway program alive.

When the first interval runs out without service, the block raises a non-maskable interrupt request. The request stays high until software services or stops the watchdog. If a second, shorter grace interval also runs out, the request drops and a chip reset pulse of fixed length is driven. After the pulse the block returns to idle.

All three durations are parameters counted in clock cycles. The register write is a plain one-cycle strobe with no back-pressure. The block accepts one write in every cycle and never stalls the writer, so it has no valid/ready pair. Both outputs are plain level signals.

Top module: `dual_stage_watchdog`

## Requirements
- R1: While `rst_n` is low, and after it is released, the block is idle with the stored key at 0 and `nmi_req` and `chip_rst` low. Asserting `rst_n` in any state returns the block to this condition.
- R2: While idle, a write with `wr_run`=0 has no effect: the block stays idle, no timeout follows, and the key is unchanged.
- R3: While idle, a write with `wr_run`=1 arms the watchdog with any key value and stores `wr_key`.
- R4: While armed, a write with `wr_run`=0 and `wr_key` equal to the stored key XOR 3'b111 stops the watchdog. `nmi_req` is low from the next cycle, and no timeout follows.
- R5: While armed, a write with `wr_run`=1 and `wr_key` equal to the stored key XOR 3'b111 restarts the first interval, stores `wr_key` and drops `nmi_req` in the next cycle.
- R6: While armed, a write whose `wr_key` is not the stored key XOR 3'b111 stores `wr_key`. Whatever the value of `wr_run`, it neither stops the watchdog nor restarts the timeout.
- R7: `nmi_req` rises exactly `NMI_CYCLES` clock edges after the edge that accepted the last start or restart, and stays high until a valid service write or the reset stage.
- R8: If no valid service arrives, `chip_rst` rises `GRACE_CYCLES` edges after `nmi_req` rose, and `nmi_req` falls at the same edge. `chip_rst` stays high for exactly `RST_PULSE_CYCLES` cycles, after which the block is idle. The two outputs are never high together.
- R9: Writes during the reset pulse are ignored: they neither shorten nor extend the pulse, and they do not change the key.
- R10: A valid service write in the cycle in which an interval expires takes priority over the expiry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | One-cycle write strobe for the control register |
| wr_run | input | 1 | Run bit of the written value |
| wr_key | input | KEY_W | Key field of the written value |
| nmi_req | output | 1 | Non-maskable interrupt request, first stage |
| chip_rst | output | 1 | Chip reset pulse, second stage |

## Verification
A write takes effect at the rising edge that samples the strobe. Its effect on `nmi_req` and `chip_rst` can be seen from the following falling edge. `nmi_req` is due after `NMI_CYCLES` further edges. `chip_rst` is due `GRACE_CYCLES` edges after that and lasts `RST_PULSE_CYCLES` cycles. The bench drives every input and samples every output on the falling edge. It counts the exact number of rising edges between a write and each check, so every vector samples either the last cycle before a transition or the first cycle after one. The expiry-edge service case is placed on the very edge where the timeout would fire.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic [1:0] {
    WD_IDLE  = 2'd0,
    WD_COUNT = 2'd1,
    WD_ALARM = 2'd2,
    WD_KILL  = 2'd3
  } wd_state_e;
endpackage

// File: rtl/wdt_interval.sv
// Single up-counter that serves every stage; the caller supplies the
// terminal value for the stage in progress.
module wdt_interval #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic [CNT_W-1:0] limit,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (clear) cnt_q <= '0;
    else            cnt_q <= cnt_q + 1'b1;
  end

  assign expired = (cnt_q == limit);
endmodule

// File: rtl/wdt_keyguard.sv
// Holds the key and turns a register write into one command.
module wdt_keyguard #(
  parameter int KEY_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  input  logic             wr_run,
  input  logic [KEY_W-1:0] wr_key,
  input  logic             armed,
  input  logic             frozen,
  output logic [KEY_W-1:0] key_q,
  output logic             do_start,
  output logic             do_restart,
  output logic             do_stop
);
  logic key_match;
  logic take_key;

  assign key_match  = (wr_key == ~key_q);
  assign do_start   = wr_valid && !frozen && !armed && wr_run;
  assign do_restart = wr_valid && armed && key_match && wr_run;
  assign do_stop    = wr_valid && armed && key_match && !wr_run;
  // every write while armed stores its key; from idle only a start does
  assign take_key   = do_start || (wr_valid && armed);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        key_q <= '0;
    else if (take_key) key_q <= wr_key;
  end
endmodule

// File: rtl/dual_stage_watchdog.sv
module dual_stage_watchdog #(
  parameter int KEY_W            = 3,
  parameter int NMI_CYCLES       = 5000000,
  parameter int GRACE_CYCLES     = 165000,
  parameter int RST_PULSE_CYCLES = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  input  logic             wr_run,
  input  logic [KEY_W-1:0] wr_key,
  output logic             nmi_req,
  output logic             chip_rst
);
  import wdt_pkg::*;

  localparam int SPAN_A   = (NMI_CYCLES > GRACE_CYCLES) ? NMI_CYCLES : GRACE_CYCLES;
  localparam int MAX_SPAN = (SPAN_A > RST_PULSE_CYCLES) ? SPAN_A : RST_PULSE_CYCLES;
  localparam int CNT_W    = $clog2(MAX_SPAN + 1);
  localparam logic [CNT_W-1:0] LIM_NMI   = CNT_W'(NMI_CYCLES - 1);
  localparam logic [CNT_W-1:0] LIM_GRACE = CNT_W'(GRACE_CYCLES - 1);
  localparam logic [CNT_W-1:0] LIM_PULSE = CNT_W'(RST_PULSE_CYCLES - 1);

  wd_state_e        state_q, state_d;
  logic             armed, frozen;
  logic [KEY_W-1:0] key_q;
  logic             do_start, do_restart, do_stop;
  logic             expired, cnt_clear;
  logic [CNT_W-1:0] limit;

  assign armed  = (state_q == WD_COUNT) || (state_q == WD_ALARM);
  assign frozen = (state_q == WD_KILL);

  wdt_keyguard #(.KEY_W(KEY_W)) u_keyguard (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_valid   (wr_valid),
    .wr_run     (wr_run),
    .wr_key     (wr_key),
    .armed      (armed),
    .frozen     (frozen),
    .key_q      (key_q),
    .do_start   (do_start),
    .do_restart (do_restart),
    .do_stop    (do_stop)
  );

  always_comb begin
    case (state_q)
      WD_ALARM: limit = LIM_GRACE;
      WD_KILL:  limit = LIM_PULSE;
      default:  limit = LIM_NMI;
    endcase
  end

  assign cnt_clear = (state_q == WD_IDLE) || do_restart || do_stop || expired;

  wdt_interval #(.CNT_W(CNT_W)) u_interval (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (cnt_clear),
    .limit   (limit),
    .expired (expired)
  );

  // service commands are checked before expiry so they win a tie
  always_comb begin
    state_d = state_q;
    case (state_q)
      WD_IDLE:  if (do_start) state_d = WD_COUNT;
      WD_COUNT: begin
        if (do_stop)         state_d = WD_IDLE;
        else if (do_restart) state_d = WD_COUNT;
        else if (expired)    state_d = WD_ALARM;
      end
      WD_ALARM: begin
        if (do_stop)         state_d = WD_IDLE;
        else if (do_restart) state_d = WD_COUNT;
        else if (expired)    state_d = WD_KILL;
      end
      WD_KILL:  if (expired) state_d = WD_IDLE;
      default:  state_d = WD_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= WD_IDLE;
    else        state_q <= state_d;
  end

  assign nmi_req  = (state_q == WD_ALARM);
  assign chip_rst = frozen;
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker #(
  parameter int KEY_W            = 3,
  parameter int RST_PULSE_CYCLES = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_valid,
  input logic             wr_run,
  input logic [KEY_W-1:0] wr_key,
  input logic             nmi_req,
  input logic             chip_rst,
  input logic [KEY_W-1:0] key_q,
  input logic             armed,
  input logic             frozen
);
  localparam int RUN_W = $clog2(RST_PULSE_CYCLES + 2);
  logic [RUN_W-1:0] rst_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rst_run <= '0;
    else if (chip_rst) rst_run <= rst_run + 1'b1;
    else               rst_run <= '0;
  end

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |-> (!nmi_req && !chip_rst));

  p_mutex_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(nmi_req && chip_rst));

  p_rst_follows_nmi_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chip_rst) |-> $past(nmi_req));

  p_rst_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
    chip_rst |-> (rst_run < RUN_W'(RST_PULSE_CYCLES)));

  p_idle_noeffect_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !frozen && wr_valid && !wr_run) |=> (!armed && $stable(key_q)));

  p_start_key_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !frozen && wr_valid && wr_run) |=> (armed && key_q == $past(wr_key)));

  p_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && wr_valid && !wr_run && wr_key == ~key_q) |=> (!armed && !nmi_req));

  p_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && wr_valid && wr_run && wr_key == ~key_q)
      |=> (armed && !nmi_req && key_q == $past(wr_key)));

  p_rekey_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && wr_valid && wr_key != ~key_q)
      |=> (key_q == $past(wr_key) && (armed || frozen)));

  p_nmi_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_req && !(wr_valid && wr_key == ~key_q)) |=> (nmi_req || chip_rst));

  p_frozen_key_r9: assert property (@(posedge clk) disable iff (!rst_n)
    frozen |=> $stable(key_q));
endmodule

bind dual_stage_watchdog wdt_checker #(
  .KEY_W            (KEY_W),
  .RST_PULSE_CYCLES (RST_PULSE_CYCLES)
) u_wdt_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_valid (wr_valid),
  .wr_run   (wr_run),
  .wr_key   (wr_key),
  .nmi_req  (nmi_req),
  .chip_rst (chip_rst),
  .key_q    (key_q),
  .armed    (armed),
  .frozen   (frozen)
);

// File: tb/dual_stage_watchdog_bench.sv
`timescale 1ns/1ps
module dual_stage_watchdog_bench;
  localparam int N = 8;
  localparam int G = 4;
  localparam int P = 3;
  localparam int ROWS = 16;

  // {run, key[2:0], idle[4:0], exp_nmi, exp_rst}
  localparam logic [10:0] VEC [ROWS] = '{
    {1'b0, 3'd5, 5'd10, 1'b0, 1'b0},  // 0  R2 idle, run=0 ignored
    {1'b1, 3'd2, 5'd7,  1'b0, 1'b0},  // 1  R3 start key 2, just before timeout
    {1'b1, 3'd5, 5'd8,  1'b1, 1'b0},  // 2  R5/R7 restart, nmi after N
    {1'b1, 3'd2, 5'd1,  1'b0, 1'b0},  // 3  R5 restart drops nmi
    {1'b1, 3'd4, 5'd6,  1'b1, 1'b0},  // 4  R6 rekey does not restart
    {1'b0, 3'd3, 5'd20, 1'b0, 1'b0},  // 5  R4 stop
    {1'b1, 3'd6, 5'd2,  1'b0, 1'b0},  // 6  R3 start key 6
    {1'b0, 3'd6, 5'd5,  1'b1, 1'b0},  // 7  R6 run=0 wrong key is no stop
    {1'b1, 3'd1, 5'd12, 1'b0, 1'b1},  // 8  R8 restart then full expiry
    {1'b1, 3'd6, 5'd0,  1'b0, 1'b1},  // 9  R9 service during pulse ignored
    {1'b0, 3'd0, 5'd1,  1'b0, 1'b0},  // 10 R9/R8 pulse ends on time
    {1'b1, 3'd6, 5'd8,  1'b1, 1'b0},  // 11 R3/R7 restart from idle
    {1'b0, 3'd1, 5'd3,  1'b0, 1'b0},  // 12 R4 stop
    {1'b1, 3'd3, 5'd7,  1'b0, 1'b0},  // 13 R3 start key 3
    {1'b1, 3'd4, 5'd7,  1'b0, 1'b0},  // 14 R10 restart on expiry edge wins
    {1'b0, 3'd3, 5'd2,  1'b0, 1'b0}   // 15 R4 stop
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_valid = 1'b0;
  logic       wr_run = 1'b0;
  logic [2:0] wr_key = 3'd0;
  logic       nmi_req, chip_rst;
  int         n_tests = 0;
  int         n_fail = 0;
  bit         finished = 1'b0;

  always #2.5 clk = ~clk;

  dual_stage_watchdog #(
    .KEY_W(3), .NMI_CYCLES(N), .GRACE_CYCLES(G), .RST_PULSE_CYCLES(P)
  ) u_dual_stage_watchdog (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_run(wr_run),
    .wr_key(wr_key), .nmi_req(nmi_req), .chip_rst(chip_rst)
  );

  function automatic string row_req(int r);
    case (r)
      0: return "R2";  1: return "R3";  2: return "R7";  3: return "R5";
      4: return "R6";  5: return "R4";  6: return "R3";  7: return "R6";
      8: return "R8";  9: return "R9";  10: return "R9"; 11: return "R3";
      12: return "R4"; 13: return "R3"; 14: return "R10"; default: return "R4";
    endcase
  endfunction

  task automatic check(string req, logic [1:0] act, logic [1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: {nmi,rst} actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic do_write(logic run, logic [2:0] key);
    wr_valid = 1'b1;
    wr_run   = run;
    wr_key   = key;
    @(posedge clk);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      summary();
    end
  end

  initial begin
    int hi_nmi;
    int hi_rst;
    @(negedge clk);
    check("R1", {nmi_req, chip_rst}, 2'b00);   // during reset
    idle(2);
    rst_n = 1'b1;
    idle(N + 4);
    check("R1", {nmi_req, chip_rst}, 2'b00);   // idle after reset

    for (int r = 0; r < ROWS; r++) begin
      do_write(VEC[r][10], VEC[r][9:7]);
      idle(int'(VEC[r][6:2]));
      check(row_req(r), {nmi_req, chip_rst}, VEC[r][1:0]);
    end

    // R8: stage lengths measured cycle by cycle from a fresh start
    do_write(1'b1, 3'd0);
    idle(N - 1);
    check("R7", {nmi_req, chip_rst}, 2'b00);
    hi_nmi = 0;
    hi_rst = 0;
    for (int i = 0; i < G + P + 6; i++) begin
      idle(1);
      if (nmi_req)  hi_nmi++;
      if (chip_rst) hi_rst++;
    end
    check("R8", 2'(hi_nmi == G), 2'b01);
    check("R8", 2'(hi_rst == P), 2'b01);
    idle(N + G + 2);
    check("R8", {nmi_req, chip_rst}, 2'b00);   // idle after the pulse

    // R1: reset asserted while the interrupt request is high
    do_write(1'b1, 3'd5);
    idle(N);
    check("R7", {nmi_req, chip_rst}, 2'b10);
    rst_n = 1'b0;
    #1;
    check("R1", {nmi_req, chip_rst}, 2'b00);
    idle(2);
    rst_n = 1'b1;
    idle(N + G + 2);
    check("R1", {nmi_req, chip_rst}, 2'b00);

    // R6: a key change in the alarm stage does not restart
    do_write(1'b1, 3'd1);
    idle(N);
    do_write(1'b1, 3'd1);                      // not the complement of 1
    check("R6", {nmi_req, chip_rst}, 2'b10);
    do_write(1'b0, 3'd6);                      // complement of 1: stop
    idle(N + G);
    check("R4", {nmi_req, chip_rst}, 2'b00);

    finished = 1'b1;
    summary();
  end
endmodule